// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block turns a pixel clock into the native timing of an interlaced raster. A frame is made of two fields, and each field has its own vertical blanking. The block drives horizontal sync, vertical sync and data enable. It also drives a field flag and the horizontal and vertical position counters. A pixel source downstream uses these outputs to place active pixels and to tell the two fields apart. All geometry is fixed by parameters at elaboration. The defaults describe a 1920x1080 interlaced raster at 50 fields per second: 2640 pixels per line, and fields of 562 and 563 lines, for 1125 lines per frame.

The vertical sequencer holds one parameter set for each field and switches between them at every field boundary. The field flag is arranged so that it always matches the active lines it labels. It changes at the first line of the vertical front porch, so during blanking it already names the field that comes next. The only controls are a clock enable and a synchronous reset.

Top module: `ivid_timing_gen`

## Requirements
- R1: `hcount` starts at 0 and rises by one on each clock with `en` high. After H_ACTIVE+H_FP+H_SYNC+H_BP-1 it wraps to 0 (2639 by default).
- R2: Horizontal sync is asserted for pixels H_ACTIVE+H_FP through H_ACTIVE+H_FP+H_SYNC-1 (2448 to 2491 by default). With HS_POL=1 asserted means high; with HS_POL=0 it means low.
- R3: `vcount` counts lines within the current field and advances when `hcount` wraps. A field 0 set has V_ACTIVE+F0_FP+F0_SYNC+F0_BP lines (562 by default) and a field 1 set has V_ACTIVE+F1_FP+F1_SYNC+F1_BP lines (563). After the last line of a field, `vcount` returns to 0 and the other set is used.
- R4: Vertical sync is asserted for whole lines V_ACTIVE+FP through V_ACTIVE+FP+SYNC-1, using the front porch and sync width of the current field. By default these are lines 542..546 in field 0 and 543..547 in field 1. VS_POL selects the polarity in the same way as HS_POL.
- R5: `de` is high exactly when `hcount` < H_ACTIVE and `vcount` < V_ACTIVE.
- R6: `field` is 0 on the active lines of field 0 and 1 on the active lines of field 1. It changes on the clock where `vcount` becomes V_ACTIVE, which is the first front-porch line, and is steady at all other times.
- R7: The fields alternate 0, 1, 0, ... so one frame spans both field line counts together (1125 lines by default).
- R8: While `en` is low, the counters and every output keep their values.
- R9: A synchronous `rst` takes priority over `en`. On the next clock the block is at pixel 0, line 0 of field 0, with `de` high and `field` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the counters |
| hsync | output | 1 | Horizontal sync, polarity set by HS_POL |
| vsync | output | 1 | Vertical sync, polarity set by VS_POL |
| de | output | 1 | Data enable for active pixels |
| field | output | 1 | Field flag, 0 or 1 |
| hcount | output | HCW (12) | Pixel position within the line |
| vcount | output | VCW (10) | Line position within the field |

## Verification
A wrong pixel counter shows up at `hcount` within one clock. It also shifts `hsync` and `de` on the same line. A vertical sequencer that picks the wrong parameter set keeps a correct active region, but it moves `vsync` by one line and changes the field length. This appears only at the first blanking of the affected field, or when the counter wraps at the end of that field. For that reason the bench uses a reduced raster, runs through several complete frames, and compares every output on every clock against a behavioural model. A field flag that is out of step is seen on the first active line of the next field.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   typedef enum logic {
      FLD_ZERO = 1'b0,
      FLD_ONE  = 1'b1
   } ivt_field_e;

   function automatic logic in_span(input int unsigned pos,
                                    input int unsigned first,
                                    input int unsigned len);
      return (pos >= first) && (pos < first + len);
   endfunction

endpackage

// File: rtl/ivt_pixel_ctr.sv
module ivt_pixel_ctr #(
   parameter int unsigned TOTAL = 2640,
   parameter int unsigned CW    = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   output logic [CW-1:0] pos,
   output logic          wrap
);
   localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

   assign wrap = en && (pos == LAST);

   always_ff @(posedge clk) begin
      if (rst)
         pos <= '0;
      else if (wrap)
         pos <= '0;
      else if (en)
         pos <= pos + 1'b1;
   end
endmodule

// File: rtl/ivt_line_seq.sv
module ivt_line_seq
   import ivt_pkg::*;
#(
   parameter int unsigned V_ACTIVE = 540,
   parameter int unsigned F0_FP    = 2,
   parameter int unsigned F0_SYNC  = 5,
   parameter int unsigned F0_BP    = 15,
   parameter int unsigned F1_FP    = 3,
   parameter int unsigned F1_SYNC  = 5,
   parameter int unsigned F1_BP    = 15,
   parameter int unsigned CW       = 10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [CW-1:0] line,
   output ivt_field_e    fset,
   output logic          vwin
);
   localparam int unsigned FP_OF   [2] = '{F0_FP, F1_FP};
   localparam int unsigned SYNC_OF [2] = '{F0_SYNC, F1_SYNC};
   localparam int unsigned TOTAL_OF[2] = '{V_ACTIVE + F0_FP + F0_SYNC + F0_BP,
                                          V_ACTIVE + F1_FP + F1_SYNC + F1_BP};

   int unsigned cur_fp, cur_sync, cur_total;
   logic        field_end;

   always_comb begin
      cur_fp    = FP_OF[fset];
      cur_sync  = SYNC_OF[fset];
      cur_total = TOTAL_OF[fset];
   end

   assign field_end = (int'(line) == int'(cur_total) - 1);
   assign vwin      = in_span(int'(line), V_ACTIVE + cur_fp, cur_sync);

   always_ff @(posedge clk) begin
      if (rst) begin
         line <= '0;
         fset <= FLD_ZERO;
      end else if (adv) begin
         if (field_end) begin
            line <= '0;
            fset <= (fset == FLD_ZERO) ? FLD_ONE : FLD_ZERO;
         end else begin
            line <= line + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ivid_timing_gen.sv
module ivid_timing_gen
   import ivt_pkg::*;
#(
   parameter int unsigned H_ACTIVE = 1920,
   parameter int unsigned H_FP     = 528,
   parameter int unsigned H_SYNC   = 44,
   parameter int unsigned H_BP     = 148,
   parameter int unsigned V_ACTIVE = 540,
   parameter int unsigned F0_FP    = 2,
   parameter int unsigned F0_SYNC  = 5,
   parameter int unsigned F0_BP    = 15,
   parameter int unsigned F1_FP    = 3,
   parameter int unsigned F1_SYNC  = 5,
   parameter int unsigned F1_BP    = 15,
   parameter bit          HS_POL   = 1'b1,
   parameter bit          VS_POL   = 1'b1,
   parameter int unsigned HCW      = 12,
   parameter int unsigned VCW      = 10
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           en,
   output logic           hsync,
   output logic           vsync,
   output logic           de,
   output logic           field,
   output logic [HCW-1:0] hcount,
   output logic [VCW-1:0] vcount
);
   localparam int unsigned H_TOTAL  = H_ACTIVE + H_FP + H_SYNC + H_BP;
   localparam int unsigned F0_TOTAL = V_ACTIVE + F0_FP + F0_SYNC + F0_BP;
   localparam int unsigned F1_TOTAL = V_ACTIVE + F1_FP + F1_SYNC + F1_BP;
   localparam int unsigned V_MAX    = (F0_TOTAL > F1_TOTAL) ? F0_TOTAL : F1_TOTAL;

   generate
      if (H_ACTIVE == 0 || H_SYNC == 0 || V_ACTIVE == 0) begin : g_bad_active
         $error("ivid_timing_gen: active widths and hsync width must be nonzero");
      end
      if (F0_SYNC == 0 || F1_SYNC == 0) begin : g_bad_vsync
         $error("ivid_timing_gen: vsync width must be nonzero in both fields");
      end
      if ((64'd1 << HCW) < H_TOTAL) begin : g_bad_hcw
         $error("ivid_timing_gen: HCW too narrow for line length");
      end
      if ((64'd1 << VCW) < V_MAX) begin : g_bad_vcw
         $error("ivid_timing_gen: VCW too narrow for field length");
      end
   endgenerate

   logic       line_adv;
   logic       hwin, vwin;
   ivt_field_e fset;

   ivt_pixel_ctr #(
      .TOTAL (H_TOTAL),
      .CW    (HCW)
   ) i_pix (
      .clk  (clk),
      .rst  (rst),
      .en   (en),
      .pos  (hcount),
      .wrap (line_adv)
   );

   ivt_line_seq #(
      .V_ACTIVE (V_ACTIVE),
      .F0_FP    (F0_FP),
      .F0_SYNC  (F0_SYNC),
      .F0_BP    (F0_BP),
      .F1_FP    (F1_FP),
      .F1_SYNC  (F1_SYNC),
      .F1_BP    (F1_BP),
      .CW       (VCW)
   ) i_line (
      .clk  (clk),
      .rst  (rst),
      .adv  (line_adv),
      .line (vcount),
      .fset (fset),
      .vwin (vwin)
   );

   assign hwin  = in_span(int'(hcount), H_ACTIVE + H_FP, H_SYNC);
   assign de    = (int'(hcount) < H_ACTIVE) && (int'(vcount) < V_ACTIVE);
   assign field = (int'(vcount) < V_ACTIVE) ? fset : ~fset;

   generate
      if (HS_POL) begin : g_hs_high
         assign hsync = hwin;
      end else begin : g_hs_low
         assign hsync = ~hwin;
      end
      if (VS_POL) begin : g_vs_high
         assign vsync = vwin;
      end else begin : g_vs_low
         assign vsync = ~vwin;
      end
   endgenerate
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
   parameter int unsigned H_ACTIVE = 1920,
   parameter int unsigned H_TOTAL  = 2640,
   parameter int unsigned V_ACTIVE = 540,
   parameter int unsigned V_MAX    = 563,
   parameter int unsigned VS_FIRST = 542,
   parameter bit          VS_POL   = 1'b1,
   parameter int unsigned HCW      = 12,
   parameter int unsigned VCW      = 10
) (
   input logic           clk,
   input logic           rst,
   input logic           en,
   input logic           vsync,
   input logic           de,
   input logic           field,
   input logic [HCW-1:0] hcount,
   input logic [VCW-1:0] vcount
);
   logic was_rst = 1'b0;

   always_ff @(posedge clk) was_rst <= rst;

   // R9: state one clock after reset
   always_ff @(posedge clk) begin
      if (was_rst === 1'b1 && !rst)
         a_r9_reset_origin: assert (hcount == '0 && vcount == '0 && de && !field)
            else $error("R9 reset origin violated");
   end

   a_r1_hcount_step: assert property (@(posedge clk) disable iff (rst)
      en && int'(hcount) != H_TOTAL - 1 |=> int'(hcount) == int'($past(hcount)) + 1);

   a_r1_hcount_wrap: assert property (@(posedge clk) disable iff (rst)
      en && int'(hcount) == H_TOTAL - 1 |=> hcount == '0);

   a_r3_vcount_bound: assert property (@(posedge clk) disable iff (rst)
      int'(vcount) < V_MAX);

   a_r4_vsync_in_blank: assert property (@(posedge clk) disable iff (rst)
      (vsync == VS_POL) |-> int'(vcount) >= VS_FIRST);

   a_r5_de_window: assert property (@(posedge clk) disable iff (rst)
      de |-> (int'(hcount) < H_ACTIVE && int'(vcount) < V_ACTIVE));

   a_r6_field_flip: assert property (@(posedge clk) disable iff (rst)
      en && int'(hcount) == H_TOTAL - 1 && int'(vcount) == V_ACTIVE - 1
      |=> field != $past(field));

   a_r6_field_steady: assert property (@(posedge clk) disable iff (rst)
      en && int'(hcount) != H_TOTAL - 1 |=> $stable(field));

   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(hcount) && $stable(vcount) && $stable(field) && $stable(de));
endmodule

bind ivid_timing_gen ivt_checker #(
   .H_ACTIVE (H_ACTIVE),
   .H_TOTAL  (H_TOTAL),
   .V_ACTIVE (V_ACTIVE),
   .V_MAX    (V_MAX),
   .VS_FIRST (V_ACTIVE + ((F0_FP < F1_FP) ? F0_FP : F1_FP)),
   .VS_POL   (VS_POL),
   .HCW      (HCW),
   .VCW      (VCW)
) i_chk (
   .clk    (clk),
   .rst    (rst),
   .en     (en),
   .vsync  (vsync),
   .de     (de),
   .field  (field),
   .hcount (hcount),
   .vcount (vcount)
);

// File: tb/test_ivid_timing_gen.sv
module test_ivid_timing_gen;
   localparam int HA = 16, HFP = 4, HSW = 3, HBP = 5;
   localparam int HT = HA + HFP + HSW + HBP;
   localparam int VA = 6;
   localparam int FP0 = 2, SY0 = 2, BP0 = 3;
   localparam int FP1 = 3, SY1 = 2, BP1 = 3;
   localparam int VT0 = VA + FP0 + SY0 + BP0;
   localparam int VT1 = VA + FP1 + SY1 + BP1;
   localparam bit HSP = 1'b0;
   localparam bit VSP = 1'b1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic hsync, vsync, de, field;
   logic [11:0] hcount;
   logic [9:0]  vcount;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   ivid_timing_gen #(
      .H_ACTIVE (HA), .H_FP (HFP), .H_SYNC (HSW), .H_BP (HBP),
      .V_ACTIVE (VA),
      .F0_FP (FP0), .F0_SYNC (SY0), .F0_BP (BP0),
      .F1_FP (FP1), .F1_SYNC (SY1), .F1_BP (BP1),
      .HS_POL (HSP), .VS_POL (VSP)
   ) i_ivid_timing_gen (
      .clk (clk), .rst (rst), .en (en),
      .hsync (hsync), .vsync (vsync), .de (de), .field (field),
      .hcount (hcount), .vcount (vcount)
   );

   // behavioural reference
   int mh = 0, mv = 0, mf = 0;
   bit armed = 1'b0;

   always @(posedge clk) begin
      if (rst) begin
         mh = 0; mv = 0; mf = 0; armed = 1'b1;
      end else if (en) begin
         if (mh == HT - 1) begin
            mh = 0;
            if (mv == ((mf == 0) ? VT0 : VT1) - 1) begin
               mv = 0;
               mf = 1 - mf;
            end else begin
               mv = mv + 1;
            end
         end else begin
            mh = mh + 1;
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // per-clock comparison, sampled at the falling edge
   always @(negedge clk) begin
      if (armed) begin
         int fp, sy;
         bit hw, vw;
         fp = (mf == 0) ? FP0 : FP1;
         sy = (mf == 0) ? SY0 : SY1;
         hw = (mh >= HA + HFP) && (mh < HA + HFP + HSW);
         vw = (mv >= VA + fp) && (mv < VA + fp + sy);
         check("R1", "hcount", int'(hcount), mh);
         check("R3", "vcount", int'(vcount), mv);
         check("R2", "hsync", int'(hsync), int'(HSP ? hw : !hw));
         check("R4", "vsync", int'(vsync), int'(VSP ? vw : !vw));
         check("R5", "de", int'(de), int'(mh < HA && mv < VA));
         check("R6", "field", int'(field), (mv < VA) ? mf : 1 - mf);
      end
   end

   // R7: frame length measured at the ports
   int prev_h = 0;
   int lines = 0;
   bit started = 1'b0;
   always @(negedge clk) begin
      if (rst) begin
         started = 1'b0; lines = 0;
      end else if (hcount == 0 && prev_h != 0) begin
         if (vcount == 0 && field == 1'b0) begin
            if (started) check("R7", "lines per frame", lines, VT0 + VT1);
            started = 1'b1;
            lines = 1;
         end else begin
            lines++;
         end
      end
      prev_h = int'(hcount);
   end

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int sh, sv, sf, sd;
      ticks(3);
      rst = 1'b0;
      // R9: reset state observed before any enabled clock
      check("R9", "hcount after reset", int'(hcount), 0);
      check("R9", "vcount after reset", int'(vcount), 0);
      check("R9", "de after reset", int'(de), 1);
      check("R9", "field after reset", int'(field), 0);
      en = 1'b1;
      ticks(1700);
      // R8: hold with enable low
      en = 1'b0;
      ticks(1);
      sh = int'(hcount); sv = int'(vcount); sf = int'(field); sd = int'(de);
      ticks(25);
      check("R8", "hcount held", int'(hcount), sh);
      check("R8", "vcount held", int'(vcount), sv);
      check("R8", "field held", int'(field), sf);
      check("R8", "de held", int'(de), sd);
      // gapped enable
      for (int i = 0; i < 600; i++) begin
         en = i[0];
         ticks(1);
      end
      en = 1'b1;
      ticks(333);
      // R9: reset in mid-frame with enable high
      rst = 1'b1;
      ticks(1);
      rst = 1'b0;
      check("R9", "hcount mid reset", int'(hcount), 0);
      check("R9", "vcount mid reset", int'(vcount), 0);
      check("R9", "field mid reset", int'(field), 0);
      check("R9", "de mid reset", int'(de), 1);
      ticks(2300);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule